// File: doc/BRIEF.md
# 64B/66B to 512B/513B Transcoder

This block squeezes a 64B/66B coded stream into 513-bit words so that a 40 Gb/s Ethernet coded stream, nominally 41.25 Gb/s, fits a transport payload at 40.078125 Gb/s. Coded blocks enter one per beat as a 2-bit sync header plus a 64-bit payload. Eight consecutive blocks form a group, and each group leaves as one 513-bit word. The two sync bits of every block and the type byte of every control block are removed. Only the compact information needed to rebuild them is kept.

A matching decoder in the same top module takes 513-bit words and returns the eight original blocks, one per beat. The two halves are independent, so a system may use only one of them or run them in loopback. Every streaming edge uses valid/ready. A transfer happens on a rising clock edge where both are high. A sender that has raised valid keeps its data unchanged until the transfer. A receiver may lower ready at any time to hold the stream back without losing data.

A control block type is transcodable only when it is a word of the 8-bit code set listed under R3, in which any two members differ in at least 4 bits. Each type is carried as a 4-bit code, its high nibble. The all-zero type is the sixteenth member of the set and is reserved for lane alignment markers, which therefore cross the transcoder like any other control block. A group with a bad sync header or an untranscodable type becomes a fixed error word. The decoder turns that word into eight invalid blocks.

Top module: `tc513_top`

## Requirements
- R1: Sync header 01 marks a data block and 10 a control block. When all eight blocks of a group are data, bit 0 of the word is 1 and block i's payload sits at bits [64*i+64 : 64*i+1].
- R2: When a group holds at least one control block, bit 0 is 0. Starting at bit 1, the word holds one 8-bit descriptor per control block in block order, then the blocks' payloads in block order. A data block keeps its 64 bits and a control block keeps only payload bits [63:8]. A descriptor holds the type code in bits [3:0] and the block position 0..7 in bits [6:4]. Its bit 7 is 1 exactly when another descriptor follows.
- R3: The control type sits in payload bits [7:0]. The transcodable types are 00, 1E, 2D, 33, 4B, 55, 66, 78, 87, 99, AA, B4, CC, D2, E1 and FF (hex), and each one's code is its high nibble. Type 00 marks a lane alignment marker and is transcoded exactly like the others.
- R4: A group in which any block has sync header 00 or 11, or in which a control block has a type outside the R3 set, is encoded as the error word: bit 0 is 0 and bits 512:1 are all 1.
- R5: The decoder rebuilds the exact eight sync headers and payloads of any word produced from a legal group, in block order, with the error flag low.
- R6: When the decoder finds a descriptor list in which a position is not greater than the previous one, or a descriptor at position 7 still announces another, it outputs eight blocks with header 00, payload 0 and the error flag high. The R4 error word is one such list.
- R7: The encoder accepts a block on each valid/ready transfer. It holds a finished word stable with its valid high until that word is taken. It refuses input only while a finished word is waiting and its consumer is not ready, and it accepts the next group's first block on the same edge on which a waiting word is taken.
- R8: The decoder presents blocks 0 to 7 in order, each held stable until taken. It accepts a new word only while it is idle or while its last block is being taken.
- R9: The encoder's output valid rises on the clock edge that accepts the eighth block of a group. The decoder's output valid rises on the edge that accepts a word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Encoder input block valid |
| in_ready | output | 1 | Encoder can take a block |
| in_hdr | input | 2 | Sync header of the input block |
| in_data | input | 64 | Payload of the input block |
| enc_valid | output | 1 | Transcoded word valid |
| enc_ready | input | 1 | Consumer takes the transcoded word |
| enc_word | output | 513 | Transcoded word |
| dec_valid | input | 1 | Decoder input word valid |
| dec_ready | output | 1 | Decoder can take a word |
| dec_word | input | 513 | Word to decode |
| out_valid | output | 1 | Decoded block valid |
| out_ready | input | 1 | Consumer takes the decoded block |
| out_hdr | output | 2 | Rebuilt sync header |
| out_data | output | 64 | Rebuilt payload |
| out_err | output | 1 | Block belongs to an undecodable word |

## Verification
The hardest case to reach is a descriptor list that breaks the ordering rules without being the all-ones error word. A correct encoder never produces one, so the bench drives the decoder input directly with hand-built lists: a falling position, a repeated position, and a continuation flag at the last position. The second hard case is an encoder output word that is taken on the same edge as the next group's first block. The bench reaches it by holding the consumer off until the encoder stalls with a block pending, and then releasing it. Every one of the 256 data/control masks is swept through both halves, and the control types rotate through the whole code set.

// File: rtl/tc513_pkg.sv
package tc513_pkg;
  localparam int GRP   = 8;
  localparam int PW    = 64;
  localparam int TW    = 8;
  localparam int CW    = 4;
  localparam int POSW  = $clog2(GRP);
  localparam int DESC  = 1 + POSW + CW;
  localparam int CPAY  = PW - TW;
  localparam int PLW   = GRP * PW;
  localparam int WW    = PLW + 1;

  localparam logic [1:0] SH_DATA = 2'b01;
  localparam logic [1:0] SH_CTRL = 2'b10;

  // Rebuild the full distance-4 type byte from its 4-bit information nibble.
  function automatic logic [TW-1:0] type_of_code(input logic [CW-1:0] c);
    logic [3:0] lo;
    lo = ({4{c[0]}} & 4'he) ^ ({4{c[1]}} & 4'hd) ^
         ({4{c[2]}} & 4'hb) ^ ({4{c[3]}} & 4'h7);
    return {c, lo};
  endfunction

  function automatic logic type_legal(input logic [TW-1:0] t);
    return type_of_code(t[TW-1:TW-CW]) == t;
  endfunction
endpackage

// File: rtl/tc513_enc.sv
module tc513_enc
  import tc513_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_hdr,
  input  logic [PW-1:0] in_data,
  output logic          enc_valid,
  input  logic          enc_ready,
  output logic [WW-1:0] enc_word
);
  localparam logic [POSW-1:0] LAST = POSW'(GRP - 1);

  logic [GRP-1:0][1:0]    bh;
  logic [GRP-1:0][PW-1:0] bd;
  logic [POSW-1:0]        cnt;
  logic                   full;
  logic                   push, pop;

  assign in_ready  = !full || enc_ready;
  assign enc_valid = full;
  assign push      = in_valid && in_ready;
  assign pop       = enc_valid && enc_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      full <= 1'b0;
    end else begin
      if (pop) full <= 1'b0;
      if (push) begin
        if (cnt == LAST) begin
          cnt  <= '0;
          full <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      bh[cnt] <= in_hdr;
      bd[cnt] <= in_data;
    end
  end

  // Packing: descriptors at the bottom, payload stream above them.
  logic [GRP-1:0] ctl;
  logic           bad;
  logic [PLW-1:0] dat, pl, dsc;
  int             k;

  always_comb begin
    bad = 1'b0;
    ctl = '0;
    dat = '0;
    pl  = '0;
    dsc = '0;
    k   = 0;
    for (int i = 0; i < GRP; i++) begin
      ctl[i] = (bh[i] == SH_CTRL);
      if (bh[i] != SH_CTRL && bh[i] != SH_DATA) bad = 1'b1;
      if (ctl[i] && !type_legal(bd[i][TW-1:0])) bad = 1'b1;
      dat[i*PW +: PW] = bd[i];
    end
    for (int i = GRP - 1; i >= 0; i--) begin
      if (ctl[i]) pl = (pl << CPAY) | PLW'(bd[i][PW-1:TW]);
      else        pl = (pl << PW) | PLW'(bd[i]);
    end
    for (int i = 0; i < GRP; i++) begin
      if (ctl[i]) begin
        dsc = dsc | (PLW'({|(ctl >> (i + 1)), POSW'(i), bd[i][TW-1:TW-CW]}) << (DESC * k));
        k   = k + 1;
      end
    end
    if (bad)             enc_word = {{PLW{1'b1}}, 1'b0};
    else if (ctl == '0)  enc_word = {dat, 1'b1};
    else                 enc_word = {(pl << (DESC * k)) | dsc, 1'b0};
  end

  assert_word_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid && !enc_ready |=> enc_valid && $stable(enc_word));

  assert_valid_after_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enc_valid) |-> $past(in_valid && in_ready));
endmodule

// File: rtl/tc513_dec.sv
module tc513_dec
  import tc513_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_valid,
  output logic          dec_ready,
  input  logic [WW-1:0] dec_word,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [1:0]    out_hdr,
  output logic [PW-1:0] out_data,
  output logic          out_err
);
  localparam logic [POSW-1:0] LAST = POSW'(GRP - 1);

  logic [GRP-1:0][1:0]    uh, dh;
  logic [GRP-1:0][PW-1:0] ud, dd;
  logic                   uerr, derr;
  logic                   busy;
  logic [POSW-1:0]        idx;
  logic                   take, give;

  // Unpack the presented word.
  logic [PLW-1:0]         s, r;
  logic [GRP-1:0]         ctl;
  logic [GRP-1:0][CW-1:0] code;
  logic [DESC-1:0]        dw;
  logic [POSW-1:0]        pos, prev;
  logic                   done, ok;
  int                     k;

  always_comb begin
    s    = dec_word[WW-1:1];
    r    = '0;
    ctl  = '0;
    code = '0;
    dw   = '0;
    pos  = '0;
    prev = '0;
    done = 1'b0;
    ok   = 1'b1;
    k    = 0;
    uh   = '0;
    ud   = '0;
    if (dec_word[0]) begin
      for (int i = 0; i < GRP; i++) begin
        uh[i] = SH_DATA;
        ud[i] = s[i*PW +: PW];
      end
    end else begin
      for (int j = 0; j < GRP; j++) begin
        if (!done) begin
          dw  = s[j*DESC +: DESC];
          pos = dw[DESC-2:CW];
          if (j > 0 && pos <= prev) ok = 1'b0;
          prev      = pos;
          ctl[pos]  = 1'b1;
          code[pos] = dw[CW-1:0];
          k         = j + 1;
          if (!dw[DESC-1])     done = 1'b1;
          else if (pos == LAST) ok  = 1'b0;
        end
      end
      if (!done) ok = 1'b0;
      r = s >> (DESC * k);
      for (int i = 0; i < GRP; i++) begin
        if (ctl[i]) begin
          uh[i] = SH_CTRL;
          ud[i] = {r[CPAY-1:0], type_of_code(code[i])};
          r     = r >> CPAY;
        end else begin
          uh[i] = SH_DATA;
          ud[i] = r[PW-1:0];
          r     = r >> PW;
        end
      end
      if (!ok) begin
        uh = '0;
        ud = '0;
      end
    end
    uerr = !ok;
  end

  assign out_valid = busy;
  assign dec_ready = !busy || (out_ready && idx == LAST);
  assign take      = dec_valid && dec_ready;
  assign give      = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (take) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (give) begin
      if (idx == LAST) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      dh   <= uh;
      dd   <= ud;
      derr <= uerr;
    end
  end

  assign out_hdr  = dh[idx];
  assign out_data = dd[idx];
  assign out_err  = derr;

  assert_block_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable({out_hdr, out_data, out_err}));

  assert_err_header_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_hdr == 2'b00);

  assert_good_header_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err |-> (out_hdr == SH_DATA || out_hdr == SH_CTRL));
endmodule

// File: rtl/tc513_top.sv
module tc513_top
  import tc513_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_hdr,
  input  logic [63:0]   in_data,
  output logic          enc_valid,
  input  logic          enc_ready,
  output logic [512:0]  enc_word,
  input  logic          dec_valid,
  output logic          dec_ready,
  input  logic [512:0]  dec_word,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [1:0]    out_hdr,
  output logic [63:0]   out_data,
  output logic          out_err
);
  tc513_enc u_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_hdr    (in_hdr),
    .in_data   (in_data),
    .enc_valid (enc_valid),
    .enc_ready (enc_ready),
    .enc_word  (enc_word)
  );

  tc513_dec u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_valid (dec_valid),
    .dec_ready (dec_ready),
    .dec_word  (dec_word),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_hdr   (out_hdr),
    .out_data  (out_data),
    .out_err   (out_err)
  );
endmodule

// File: tb/sim_tc513_top.sv
module sim_tc513_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready;
  logic [1:0] in_hdr;
  logic [63:0] in_data;
  logic enc_valid, enc_ready;
  logic [512:0] enc_word;
  logic dec_valid, dec_ready;
  logic [512:0] dec_word;
  logic out_valid, out_ready;
  logic [1:0] out_hdr;
  logic [63:0] out_data;
  logic out_err;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tc513_top u0 (.*);

  int checks = 0;
  int failures = 0;
  int cap_n = 0;
  int rx_n = 0;
  logic bp = 1'b0;
  logic [512:0] cap_q [512];
  logic [1:0]  rx_h [16];
  logic [63:0] rx_d [16];
  logic        rx_e [16];

  localparam logic [7:0] LEGAL [16] = '{8'h00, 8'h1e, 8'h2d, 8'h33, 8'h4b, 8'h55, 8'h66, 8'h78,
                                        8'h87, 8'h99, 8'haa, 8'hb4, 8'hcc, 8'hd2, 8'he1, 8'hff};
  localparam logic [512:0] ERRW = {{512{1'b1}}, 1'b0};

  // Monitors sample after the negedge drivers have settled.
  always @(negedge clk) begin
    #2;
    if (enc_valid && enc_ready) begin
      cap_q[cap_n % 512] = enc_word;
      cap_n++;
    end
    if (out_valid && out_ready && rx_n < 16) begin
      rx_h[rx_n] = out_hdr;
      rx_d[rx_n] = out_data;
      rx_e[rx_n] = out_err;
      rx_n++;
    end
  end

  always @(negedge clk) out_ready <= bp ? ~out_ready : 1'b1;

  function automatic logic is_legal(input logic [7:0] t);
    for (int i = 0; i < 16; i++) if (LEGAL[i] == t) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [63:0] pr(input int a, input int b);
    logic [63:0] x;
    x = 64'h9e3779b97f4a7c15 * 64'(a * 8 + b + 1);
    x = x ^ (x >> 29) ^ (x << 17);
    return x;
  endfunction

  // Bench model of the word format, written bit by bit from R1..R4.
  function automatic logic [512:0] m_enc(input logic [7:0][1:0] h, input logic [7:0][63:0] d);
    logic [512:0] w;
    logic [7:0] isc;
    logic [7:0] desc;
    logic bad;
    int p, nctl, seen;
    bad = 0; isc = 0; nctl = 0; seen = 0; w = '0;
    for (int j = 0; j < 8; j++) begin
      if (h[j] == 2'b10) begin isc[j] = 1; nctl++; end
      else if (h[j] != 2'b01) bad = 1;
      if (isc[j] && !is_legal(d[j][7:0])) bad = 1;
    end
    if (bad) return ERRW;
    if (isc == 0) begin
      w[0] = 1'b1;
      for (int j = 0; j < 8; j++)
        for (int b = 0; b < 64; b++) w[1 + 64 * j + b] = d[j][b];
      return w;
    end
    p = 1;
    for (int j = 0; j < 8; j++) begin
      if (isc[j]) begin
        seen++;
        desc = {(seen < nctl), 3'(j), d[j][7:4]};
        for (int b = 0; b < 8; b++) begin w[p] = desc[b]; p++; end
      end
    end
    for (int j = 0; j < 8; j++)
      for (int b = (isc[j] ? 8 : 0); b < 64; b++) begin w[p] = d[j][b]; p++; end
    return w;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [512:0] act, input logic [512:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] h, input logic [63:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_hdr = h; in_data = d;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic feed(input logic [512:0] w);
    @(negedge clk);
    dec_valid = 1'b1; dec_word = w;
    while (!dec_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    dec_valid = 1'b0;
  endtask

  task automatic check_blocks(input logic [7:0][1:0] h, input logic [7:0][63:0] d, input logic err, input string tag);
    logic ok;
    int bad_j;
    ok = 1; bad_j = 0;
    for (int j = 7; j >= 0; j--) begin
      if (err ? (rx_h[j] !== 2'b00 || rx_d[j] !== 64'd0 || rx_e[j] !== 1'b1)
              : (rx_h[j] !== h[j] || rx_d[j] !== d[j] || rx_e[j] !== 1'b0)) begin
        ok = 0; bad_j = j;
      end
    end
    check(ok, tag, {rx_e[bad_j], rx_h[bad_j], rx_d[bad_j]},
          err ? {1'b1, 2'b00, 64'd0} : {1'b0, h[bad_j], d[bad_j]});
  endtask

  task automatic run_group(input logic [7:0][1:0] h, input logic [7:0][63:0] d, input string tag);
    logic [512:0] exp;
    int t0;
    exp = m_enc(h, d);
    t0 = cap_n;
    for (int j = 0; j < 8; j++) push(h[j], d[j]);
    @(negedge clk);
    in_valid = 1'b0;
    while (cap_n == t0) @(negedge clk);
    check(cap_q[t0 % 512] === exp, tag, cap_q[t0 % 512], exp);
    rx_n = 0;
    feed(cap_q[t0 % 512]);
    while (rx_n < 8) @(negedge clk);
    check_blocks(h, d, exp === ERRW, exp === ERRW ? "R6 decode of error word" : "R5 round trip");
  endtask

  task automatic decode_bad(input logic [15:0] descs, input string tag);
    logic [512:0] w;
    logic [7:0][1:0] h0;
    logic [7:0][63:0] d0;
    h0 = '0; d0 = '0;
    w = {pr(7, 1), pr(7, 2), pr(7, 3), pr(7, 4), pr(7, 5), pr(7, 6), pr(7, 7), pr(7, 8), 1'b0};
    w[16:1] = descs;
    rx_n = 0;
    feed(w);
    while (rx_n < 8) @(negedge clk);
    check_blocks(h0, d0, 1'b1, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0][1:0] h;
    logic [7:0][63:0] d;
    logic [512:0] expa, expb;
    int t0;
    rst_n = 1'b0; in_valid = 1'b0; in_hdr = '0; in_data = '0;
    enc_ready = 1'b1; dec_valid = 1'b0; dec_word = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!enc_valid && in_ready, "R7 reset state", {enc_valid, in_ready}, 2'b01);
    check(!out_valid && dec_ready, "R8 reset state", {out_valid, dec_ready}, 2'b01);

    // R9: valid rises exactly on the edge of the eighth block.
    for (int j = 0; j < 8; j++) begin
      h[j] = 2'b01; d[j] = pr(900, j);
    end
    t0 = cap_n;
    for (int j = 0; j < 7; j++) push(h[j], d[j]);
    #1 check(enc_valid === 1'b0, "R9 no word after seven blocks", enc_valid, 1'b0);
    push(h[7], d[7]);
    #1 check(enc_valid === 1'b1, "R9 word after eighth block", enc_valid, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    while (cap_n == t0) @(negedge clk);
    check(cap_q[t0 % 512] === m_enc(h, d), "R1 all-data word", cap_q[t0 % 512], m_enc(h, d));
    rx_n = 0;
    feed(cap_q[t0 % 512]);
    #1 check(out_valid === 1'b1, "R9 decoder valid after word", out_valid, 1'b1);
    while (rx_n < 8) @(negedge clk);
    check_blocks(h, d, 1'b0, "R5 all-data round trip");

    // R1/R2/R3/R5: every data/control mask, types rotating through the set.
    for (int m = 0; m < 256; m++) begin
      for (int j = 0; j < 8; j++) begin
        if (m[j]) begin
          h[j] = 2'b10;
          d[j] = {pr(m, j)[63:8], LEGAL[(m + 3 * j) % 16]};
        end else begin
          h[j] = 2'b01;
          d[j] = pr(m, j);
        end
      end
      run_group(h, d, m == 0 ? "R1 data sweep" : "R2 control sweep");
    end

    // R3: alignment markers (type 00) in every slot.
    for (int j = 0; j < 8; j++) begin
      h[j] = 2'b10; d[j] = {pr(500, j)[63:8], 8'h00};
    end
    run_group(h, d, "R3 marker group");

    // R4: bad sync header at every position, both bad codes.
    for (int p = 0; p < 8; p++) begin
      for (int b = 0; b < 2; b++) begin
        for (int j = 0; j < 8; j++) begin
          h[j] = (j % 3 == 0) ? 2'b10 : 2'b01;
          d[j] = (j % 3 == 0) ? {pr(p, j)[63:8], 8'h78} : pr(p, j);
        end
        h[p] = b ? 2'b11 : 2'b00;
        run_group(h, d, "R4 bad sync header");
      end
    end
    // R4: untranscodable control types.
    for (int j = 0; j < 8; j++) begin h[j] = 2'b01; d[j] = pr(600, j); end
    h[3] = 2'b10; d[3] = {pr(600, 3)[63:8], 8'h1f};
    run_group(h, d, "R4 illegal type 1F");
    h[3] = 2'b10; d[3] = {pr(601, 3)[63:8], 8'h3c};
    run_group(h, d, "R4 illegal type 3C");

    // R6: malformed descriptor lists fed straight to the decoder.
    decode_bad({8'h12, 8'hb1}, "R6 falling position");
    decode_bad({8'h15, 8'h95}, "R6 repeated position");
    decode_bad({8'h00, 8'hf2}, "R6 continuation at position 7");

    // R7: stalled word, then pop and push on one edge.
    for (int j = 0; j < 8; j++) begin
      h[j] = j[0] ? 2'b10 : 2'b01;
      d[j] = j[0] ? {pr(700, j)[63:8], LEGAL[j + 5]} : pr(700, j);
    end
    expa = m_enc(h, d);
    @(negedge clk);
    enc_ready = 1'b0;
    t0 = cap_n;
    for (int j = 0; j < 8; j++) push(h[j], d[j]);
    @(negedge clk);
    in_valid = 1'b1; in_hdr = 2'b01; in_data = pr(701, 0);
    for (int c = 0; c < 3; c++) begin
      #1;
      check(enc_valid && enc_word === expa, "R7 word held while stalled", enc_word, expa);
      check(in_ready === 1'b0, "R7 input refused while stalled", in_ready, 1'b0);
      @(negedge clk);
    end
    enc_ready = 1'b1;
    #1 check(in_ready === 1'b1, "R7 input accepted with pop", in_ready, 1'b1);
    @(posedge clk);
    for (int j = 0; j < 8; j++) begin h[j] = 2'b01; d[j] = pr(701, j); end
    for (int j = 1; j < 8; j++) push(h[j], d[j]);
    @(negedge clk);
    in_valid = 1'b0;
    expb = m_enc(h, d);
    while (cap_n < t0 + 2) @(negedge clk);
    check(cap_q[t0 % 512] === expa, "R7 stalled word delivered", cap_q[t0 % 512], expa);
    check(cap_q[(t0 + 1) % 512] === expb, "R7 next group intact", cap_q[(t0 + 1) % 512], expb);

    // R8: decoder under back-pressure.
    for (int j = 0; j < 8; j++) begin
      h[j] = (j == 2 || j == 6) ? 2'b10 : 2'b01;
      d[j] = (j == 2 || j == 6) ? {pr(800, j)[63:8], 8'hd2} : pr(800, j);
    end
    bp = 1'b1;
    rx_n = 0;
    feed(m_enc(h, d));
    while (rx_n < 2) @(negedge clk);
    #1 check(dec_ready === 1'b0, "R8 busy decoder refuses word", dec_ready, 1'b0);
    while (rx_n < 8) @(negedge clk);
    check_blocks(h, d, 1'b0, "R8 ordered blocks under back-pressure");
    bp = 1'b0;
    repeat (4) @(negedge clk);
    check(rx_n == 8, "R8 no extra blocks", 513'(rx_n), 513'd8);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule